// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM Core

This block is a cycle-accurate model of a synchronous burst SRAM whose read data flows through without a pipeline register. A small array of words is held in byte lanes; each rising clock edge samples the address, three chip selects, two address strobes, an advance input and the write enables. From these it classifies the cycle as a deselect, a burst start, a burst advance or a burst hold, and as a read or a write. The data bus is bidirectional: during selected reads it presents the array word at the registered address in the cycle after that edge, gated by an asynchronous output enable, and during writes the data on the bus is captured on the sampling edge.

The two address strobes follow different rules. The processor strobe needs the master select and always starts a read. The controller strobe is ignored while the processor strobe takes effect, and otherwise starts either a read or a write depending on the write enables. An asynchronous sleep input floats the bus at once and, after a short settling delay, freezes the core while keeping its contents. A static pin picks between a wrapping linear and an exclusive-or burst order over the two low address bits.

Top module: `ssb_sram_top`

## Requirements
- R1: A cycle is a deselect when the controller strobe is low with any select inactive and the processor strobe not taking effect, or when the processor strobe is low with cs_main_n low but cs_pos low or cs_neg_n high. After a deselect, dq is high-impedance, and advance or hold cycles neither write nor drive until a new start.
- R2: While cs_main_n is high, a low processor strobe has no effect: with the controller strobe high the advance input decides the cycle, and a low controller strobe gives a deselect.
- R3: Processor strobe low with all selects active (cs_main_n=0, cs_pos=1, cs_neg_n=0) starts a read at addr whatever the write enables and the controller strobe are; nothing is written on that edge.
- R4: Controller strobe low, processor strobe high and all selects active starts a burst at addr; the write enables sampled on that edge choose read or write, and a write stores the bus data at addr.
- R5: Write decode: wr_all_n low writes both lanes; otherwise, with wr_byte_n low, lane i is written when lane_we_n[i] is low; in every other case the cycle is a read. Lane 0 is dq[8:0], lane 1 is dq[17:9].
- R6: With both strobes high (or the processor strobe blocked), adv_n low moves the burst to the next address and adv_n high keeps the current address; either may read or write.
- R7: Burst order over addr[1:0] for the k-th access from start s: with lin_order=1 the offset is (s+k) mod 4, with lin_order=0 it is s XOR k; addr[5:2] stay fixed.
- R8: After a selected read edge, dq shows the array word at the address registered on that edge before the next edge, with oe_n low.
- R9: During a read, oe_n high floats dq without waiting for a clock edge.
- R10: After any edge that writes, dq is not driven by the block until the next edge, regardless of oe_n.
- R11: sleep high floats dq at once; from the third edge after sleep rises until the second edge after it falls, all other inputs are ignored (no write, no address or state change) and contents are kept.
- R12: While rst_n is low the core is deselected and dq is high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | External word address |
| cs_main_n | input | 1 | Master select, active low; gates the processor strobe |
| cs_pos | input | 1 | Select, active high |
| cs_neg_n | input | 1 | Select, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write both lanes, active low |
| wr_byte_n | input | 1 | Enables per-lane writes, active low |
| lane_we_n | input | 2 | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request, active high |
| lin_order | input | 1 | Burst order: 1 linear, 0 exclusive-or |
| dq | inout | 18 | Bidirectional data bus |

## Verification
The assertions assume that lin_order does not change in the cycle after a burst step, that strobes, selects and write enables carry known levels at every edge, and that reset is asserted long enough to clear the sleep settling stages. The directed stimulus changes inputs only 2 ns after a rising edge, keeps lin_order fixed within a burst, holds sleep high for several edges at a time, and drives dq from the bench only on write edges, releasing it before looking at the bus so that a floating bus reads as all ones through the bench pull-ups.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [2:0] {
    OP_DESEL,
    OP_START,
    OP_NEXT,
    OP_HOLD
  } op_e;

  // offset of the k-th beat from start b: wrapping add or exclusive-or
  function automatic logic [BURST_W-1:0] seq_off(input logic lin,
                                                 input logic [BURST_W-1:0] b,
                                                 input logic [BURST_W-1:0] k);
    return lin ? (b + k) : (b ^ k);
  endfunction
endpackage

// File: rtl/ssb_cmd_dec.sv
module ssb_cmd_dec
  import ssb_pkg::*;
#(
  parameter int NL = 2
) (
  input  logic          cs_main_n,
  input  logic          cs_pos,
  input  logic          cs_neg_n,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NL-1:0] lane_we_n,
  output op_e           op,
  output logic [NL-1:0] lane_wr
);
  logic          all_on;
  logic          proc_go;
  logic [NL-1:0] req_lanes;

  always_comb begin
    all_on  = !cs_main_n && cs_pos && !cs_neg_n;
    proc_go = !strb_proc_n && !cs_main_n;
    if (!wr_all_n)       req_lanes = '1;
    else if (!wr_byte_n) req_lanes = ~lane_we_n;
    else                 req_lanes = '0;

    if (proc_go) begin
      op      = all_on ? OP_START : OP_DESEL;
      lane_wr = '0;
    end else if (!strb_ctrl_n) begin
      op      = all_on ? OP_START : OP_DESEL;
      lane_wr = all_on ? req_lanes : '0;
    end else begin
      op      = adv_n ? OP_HOLD : OP_NEXT;
      lane_wr = req_lanes;
    end
  end
endmodule

// File: rtl/ssb_burst.sv
module ssb_burst
  import ssb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic          step,
  input  logic          lin_order,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] eff_addr
);
  localparam int OW = BURST_W;

  logic [AW-1:OW] hi_q, hi_d;
  logic [OW-1:0]  base_q, base_d, cnt_q, cnt_d;

  always_comb begin
    hi_d   = load ? load_addr[AW-1:OW] : hi_q;
    base_d = load ? load_addr[OW-1:0]  : base_q;
    if (load)      cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
    eff_addr = {hi_d, seq_off(lin_order, base_d, cnt_d)};
    cur_addr = {hi_q, seq_off(lin_order, base_q, cnt_q)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en) begin
      hi_q   <= hi_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  // R6: a hold cycle keeps the burst address
  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !step) |=> $stable(cur_addr));

  // R7: a linear step moves the low offset by one, wrapping in two bits
  assert_lin_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step && !load && lin_order) |=>
      (!lin_order || (cur_addr[OW-1:0] == $past(cur_addr[OW-1:0]) + 2'd1)));
endmodule

// File: rtl/ssb_lanes.sv
module ssb_lanes #(
  parameter int AW = 6,
  parameter int BW = 9,
  parameter int NL = 2
) (
  input  logic           clk,
  input  logic [NL-1:0]  we,
  input  logic [AW-1:0]  waddr,
  input  logic [NL*BW-1:0] wdata,
  input  logic [AW-1:0]  raddr,
  output logic [NL*BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [BW-1:0] arr [DEPTH];
    always_ff @(posedge clk) begin
      if (we[g]) arr[waddr] <= wdata[g*BW +: BW];
    end
    assign rdata[g*BW +: BW] = arr[raddr];
  end
endmodule

// File: rtl/ssb_sram_top.sv
module ssb_sram_top
  import ssb_pkg::*;
#(
  parameter int AW = 6,
  parameter int BW = 9,
  parameter int NL = 2,
  parameter int SLEEP_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          cs_main_n,
  input  logic          cs_pos,
  input  logic          cs_neg_n,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic          wr_all_n,
  input  logic          wr_byte_n,
  input  logic [NL-1:0] lane_we_n,
  input  logic          oe_n,
  input  logic          sleep,
  input  logic          lin_order,
  inout  wire  [NL*BW-1:0] dq
);
  localparam int DW = NL * BW;

  op_e           op;
  logic [NL-1:0] lane_wr, lane_we;
  logic [SLEEP_STAGES-1:0] slp_q;
  logic          ign, act, load, step;
  logic          sel_q, sel_d, wr_q, wr_d, drv;
  logic [AW-1:0] cur_addr, eff_addr;
  logic [DW-1:0] rdata;

  // sleep settling chain: core freezes once the request has aged
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slp_q <= '0;
    else        slp_q <= {slp_q[SLEEP_STAGES-2:0], sleep};
  end
  assign ign = slp_q[SLEEP_STAGES-1];
  assign act = !ign;

  ssb_cmd_dec #(.NL(NL)) u_dec (
    .cs_main_n  (cs_main_n),
    .cs_pos     (cs_pos),
    .cs_neg_n   (cs_neg_n),
    .strb_proc_n(strb_proc_n),
    .strb_ctrl_n(strb_ctrl_n),
    .adv_n      (adv_n),
    .wr_all_n   (wr_all_n),
    .wr_byte_n  (wr_byte_n),
    .lane_we_n  (lane_we_n),
    .op         (op),
    .lane_wr    (lane_wr)
  );

  assign load = (op == OP_START);
  assign step = (op == OP_NEXT);

  ssb_burst #(.AW(AW)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (act),
    .load     (load),
    .step     (step),
    .lin_order(lin_order),
    .load_addr(addr),
    .cur_addr (cur_addr),
    .eff_addr (eff_addr)
  );

  always_comb begin
    if (act && (load || ((op == OP_NEXT || op == OP_HOLD) && sel_q)))
      lane_we = lane_wr;
    else
      lane_we = '0;
    case (op)
      OP_START: sel_d = 1'b1;
      OP_DESEL: sel_d = 1'b0;
      default:  sel_d = sel_q;
    endcase
    wr_d = |lane_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
    end else if (act) begin
      sel_q <= sel_d;
      wr_q  <= wr_d;
    end
  end

  ssb_lanes #(.AW(AW), .BW(BW), .NL(NL)) u_lanes (
    .clk  (clk),
    .we   (lane_we),
    .waddr(eff_addr),
    .wdata(dq),
    .raddr(cur_addr),
    .rdata(rdata)
  );

  assign drv = sel_q && !wr_q && !oe_n && !sleep && !ign;
  assign dq  = drv ? rdata : {DW{1'bz}};

  // R1: a deselect leaves the bus undriven in the following cycle
  assert_desel_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act && op == OP_DESEL) |=> !drv);

  // R2: a blocked processor strobe never starts or deselects on its own
  assert_proc_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_main_n && strb_ctrl_n) |-> (op == OP_NEXT || op == OP_HOLD));

  // R3: an accepted processor strobe never writes
  assert_proc_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n && !cs_main_n) |-> (lane_we == '0));

  // R10: after a writing edge the block keeps off the bus
  assert_write_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_we) |=> !drv);

  // R11: frozen core keeps its address and writes nothing
  assert_sleep_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ign |=> ($stable(cur_addr) && $stable(sel_q)));

  assert_sleep_float_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !drv);
endmodule

// File: tb/sim_ssb_sram_top.sv
module sim_ssb_sram_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  addr;
  logic        cs_main_n, cs_pos, cs_neg_n;
  logic        strb_proc_n, strb_ctrl_n, adv_n;
  logic        wr_all_n, wr_byte_n;
  logic [1:0]  lane_we_n;
  logic        oe_n, sleep, lin_order;
  logic [17:0] tb_d;
  logic        tb_en;
  wire  [17:0] dq;

  localparam logic [17:0] FLOAT = 18'h3FFFF;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  logic [17:0] ref_mem [64];

  always #4 clk = ~clk;

  assign dq = tb_en ? tb_d : 18'bz;
  for (genvar i = 0; i < 18; i++) begin : g_pu
    pullup (dq[i]);
  end

  ssb_sram_top u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .cs_main_n(cs_main_n), .cs_pos(cs_pos), .cs_neg_n(cs_neg_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_we_n(lane_we_n),
    .oe_n(oe_n), .sleep(sleep), .lin_order(lin_order), .dq(dq)
  );

  function automatic logic [5:0] baddr(input logic [5:0] s, input int k, input bit lin);
    logic [1:0] kk;
    kk = k[1:0];
    return {s[5:2], lin ? (s[1:0] + kk) : (s[1:0] ^ kk)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [17:0] a, input logic [17:0] e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, a, e, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_cs(input bit on);
    cs_main_n = !on;
    cs_pos    = on;
    cs_neg_n  = !on;
  endtask

  task automatic idle_in();
    strb_proc_n = 1'b1;
    strb_ctrl_n = 1'b1;
    adv_n       = 1'b1;
    wr_all_n    = 1'b1;
    wr_byte_n   = 1'b1;
    lane_we_n   = 2'b11;
    tb_en       = 1'b0;
  endtask

  // release the bus after a write edge and confirm the block is silent
  task automatic release_chk(input string req);
    tb_en = 1'b0;
    #1;
    chk(dq === FLOAT, req, dq, FLOAT);
  endtask

  // R4 R6 R7 R10: controller-started write burst of four beats
  task automatic t_write_burst(input logic [5:0] s, input bit lin, input logic [17:0] d0);
    lin_order = lin;
    set_cs(1);
    addr = s; strb_ctrl_n = 1'b0; wr_all_n = 1'b0;
    tb_en = 1'b1; tb_d = d0;
    tick();
    ref_mem[baddr(s, 0, lin)] = d0;
    release_chk("R10 write start");
    for (int k = 1; k < 4; k++) begin
      strb_ctrl_n = 1'b1; adv_n = 1'b0; wr_all_n = 1'b0;
      tb_en = 1'b1; tb_d = d0 + 18'(k * 3);
      tick();
      ref_mem[baddr(s, k, lin)] = d0 + 18'(k * 3);
      release_chk("R10 write advance");
    end
    idle_in();
    set_cs(0);
  endtask

  // R3 R6 R7 R8: processor-started read, write enables low, bus driven with junk
  task automatic t_read_burst(input logic [5:0] s, input bit lin);
    int k;
    lin_order = lin;
    set_cs(1);
    addr = s; strb_proc_n = 1'b0; wr_all_n = 1'b0;
    tb_en = 1'b1; tb_d = 18'h3FFFF;
    tick();
    idle_in();
    #1;
    chk(dq === ref_mem[s], "R3 R8 start read", dq, ref_mem[s]);
    k = 0;
    for (int i = 0; i < 6; i++) begin
      adv_n = (i % 3 == 2) ? 1'b1 : 1'b0;
      tick();
      if (i % 3 != 2) k++;
      #1;
      chk(dq === ref_mem[baddr(s, k, lin)], (i % 3 == 2) ? "R6 hold" : "R7 advance",
          dq, ref_mem[baddr(s, k, lin)]);
    end
    idle_in();
    set_cs(0);
  endtask

  // R5: lane decode
  task automatic t_lanes();
    logic [17:0] e;
    lin_order = 1'b1;
    set_cs(1);
    addr = 6'h20; strb_ctrl_n = 1'b0; wr_all_n = 1'b0;
    tb_en = 1'b1; tb_d = 18'h2AB55;
    tick(); ref_mem[6'h20] = 18'h2AB55; release_chk("R5 full write");
    // lane 0 only
    idle_in(); strb_ctrl_n = 1'b0; wr_byte_n = 1'b0; lane_we_n = 2'b10;
    tb_en = 1'b1; tb_d = 18'h3FFFF;
    tick(); ref_mem[6'h20][8:0] = 9'h1FF; release_chk("R5 lane0 write");
    // lane 1 only on a hold cycle
    idle_in(); wr_byte_n = 1'b0; lane_we_n = 2'b01;
    tb_en = 1'b1; tb_d = 18'h00000;
    tick(); ref_mem[6'h20][17:9] = 9'h000; release_chk("R5 lane1 write");
    // lane enables without byte enable: read
    idle_in(); strb_ctrl_n = 1'b0; lane_we_n = 2'b00;
    tick(); idle_in(); #1;
    e = ref_mem[6'h20];
    chk(dq === e, "R5 no-byte-enable read", dq, e);
    chk(e == 18'h001FF, "R5 merged lanes", e, 18'h001FF);
    set_cs(0);
  endtask

  // R1: deselect forms, and advance writes while deselected
  task automatic t_desel();
    lin_order = 1'b1;
    set_cs(1); addr = 6'h0A; strb_proc_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === ref_mem[6'h0A], "R1 read before deselect", dq, ref_mem[6'h0A]);
    cs_pos = 1'b0; strb_ctrl_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === FLOAT, "R1 controller deselect", dq, FLOAT);
    adv_n = 1'b0; wr_all_n = 1'b0; tb_en = 1'b1; tb_d = 18'h12345;
    tick(); idle_in(); #1;
    chk(dq === FLOAT, "R1 advance write while deselected", dq, FLOAT);
    set_cs(1); addr = 6'h0B; strb_proc_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === ref_mem[6'h0B], "R1 no write while deselected", dq, ref_mem[6'h0B]);
    cs_neg_n = 1'b1; strb_proc_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === FLOAT, "R1 processor deselect", dq, FLOAT);
    set_cs(0);
  endtask

  // R2 R4: master select blocks only the processor strobe; priority
  task automatic t_master();
    lin_order = 1'b0;
    set_cs(1); addr = 6'h15; strb_proc_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === ref_mem[6'h15], "R2 start", dq, ref_mem[6'h15]);
    cs_main_n = 1'b1; strb_proc_n = 1'b0; adv_n = 1'b0; addr = 6'h00;
    tick(); idle_in(); #1;
    chk(dq === ref_mem[6'h14], "R2 blocked strobe advances", dq, ref_mem[6'h14]);
    cs_main_n = 1'b1; strb_proc_n = 1'b0; strb_ctrl_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === FLOAT, "R2 controller deselect", dq, FLOAT);
    // both strobes low, selects on, write enables low: read wins, no write
    set_cs(1); addr = 6'h16; strb_proc_n = 1'b0; strb_ctrl_n = 1'b0; wr_all_n = 1'b0;
    tb_en = 1'b1; tb_d = 18'h3FFFF;
    tick(); idle_in(); #1;
    chk(dq === ref_mem[6'h16], "R4 processor strobe priority", dq, ref_mem[6'h16]);
    set_cs(0);
  endtask

  // R9: asynchronous output enable
  task automatic t_oe();
    lin_order = 1'b1;
    set_cs(1); addr = 6'h0B; strb_proc_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === ref_mem[6'h0B], "R9 read", dq, ref_mem[6'h0B]);
    oe_n = 1'b1; #1;
    chk(dq === FLOAT, "R9 oe high floats", dq, FLOAT);
    oe_n = 1'b0; #1;
    chk(dq === ref_mem[6'h0B], "R9 oe low drives", dq, ref_mem[6'h0B]);
    set_cs(0);
  endtask

  // R11: sleep floats, freezes and retains
  task automatic t_sleep();
    lin_order = 1'b1;
    set_cs(1); addr = 6'h08; strb_proc_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === ref_mem[6'h08], "R11 read before sleep", dq, ref_mem[6'h08]);
    sleep = 1'b1; #1;
    chk(dq === FLOAT, "R11 sleep floats", dq, FLOAT);
    repeat (3) tick();
    addr = 6'h09; strb_ctrl_n = 1'b0; wr_all_n = 1'b0; tb_en = 1'b1; tb_d = 18'h00000;
    repeat (2) tick();
    idle_in(); sleep = 1'b0;
    repeat (3) tick();
    #1;
    chk(dq === ref_mem[6'h08], "R11 state kept", dq, ref_mem[6'h08]);
    addr = 6'h09; strb_proc_n = 1'b0;
    tick(); idle_in(); #1;
    chk(dq === ref_mem[6'h09], "R11 write ignored", dq, ref_mem[6'h09]);
    set_cs(0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; tb_d = '0;
    idle_in(); set_cs(0);
    oe_n = 1'b0; sleep = 1'b0; lin_order = 1'b1;
    repeat (3) tick();
    #1;
    chk(dq === FLOAT, "R12 reset float", dq, FLOAT);
    rst_n = 1'b1;
    tick();
    t_write_burst(6'h0A, 1'b1, 18'h01234);
    t_write_burst(6'h15, 1'b0, 18'h0ABCD);
    t_read_burst(6'h0A, 1'b1);
    t_read_burst(6'h15, 1'b0);
    t_lanes();
    t_desel();
    t_master();
    t_oe();
    t_sleep();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule